// File: doc/BRIEF.md
# Lagged Spatial Covariance Estimator

This block estimates lagged spatial covariance matrices from chip-rate complex samples on several receive antennas. Each accepted chip carries one complex sample per antenna. Over a window of `WIN` accepted chips, the block accumulates the products `x_i[n] * conj(x_j[n-l])` for every antenna pair `(i, j)` and every non-negative lag `l` up to `LMAX`. Samples from before the start of the window count as zero.

The products are formed on a small pool of `NMUL` pipelined complex multipliers under a fixed schedule. Each accepted chip occupies the pool for `STEPS = ceil((LMAX+1)*NANT*NANT / NMUL)` cycles. After the last chip of a window, a shuffle pass reads one accumulator per cycle. It scales the value with an arithmetic right shift, saturates it, and writes it into the result memory. In the same cycle it also writes the conjugate-transposed copy into the negative-lag half of that memory.

A one-cycle done pulse marks the end of the shuffle pass. From then on the results can be read through an asynchronous read port. A stall input freezes the block at any cycle, which lets the caller adjust the update rate.

Top module: `mcov_top`

## Requirements
- R1: For lag `l` in `0..LMAX`, memory word `((l+LMAX)*NANT+i)*NANT+j` holds `E_l[i][j] = sum over window chips n of x_i[n]*conj(x_j[n-l])`, with `x[n-l] = 0` when `n-l < 0`. The real part is in bits `[2*OW-1:OW]` and the imaginary part in `[OW-1:0]`.
- R2: For lag `l` in `1..LMAX`, memory word `((LMAX-l)*NANT+i)*NANT+j` holds the conjugate of the stored `E_l[j][i]`.
- R3: Each real and imaginary sum is stored as the sum arithmetically shifted right by `SHIFT` bits, which rounds toward minus infinity.
- R4: A shifted value outside `±(2^(OW-1)-1)` is stored clamped to that bound, keeping its sign.
- R5: A window consists of `WIN` accepted chips. Accumulators and the sample history are cleared when a shuffle pass ends, so a new window's results do not depend on earlier windows.
- R6: `done` is high for exactly one cycle. It rises at the clock edge `STEPS+1+(LMAX+1)*NANT*NANT` edges after the edge that accepts the last chip of a window, provided no stall occurs. The memory holds the new results from that point.
- R7: While `stall` is high, the schedule, pipeline, accumulators and shuffle hold their state, and a `chipValid` strobe is ignored. A stall only delays the results and does not change them.
- R8: A `chipValid` strobe that arrives while the multiplier schedule or the shuffle is running is ignored.
- R9: After reset, `done` is low and every memory word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chipValid | input | 1 | Strobe marking a new chip sample set |
| stall | input | 1 | Freezes the estimator while high |
| chipRe | input | NANT*SW | Real parts; antenna a at bits [a*SW +: SW], signed |
| chipIm | input | NANT*SW | Imaginary parts, same layout, signed |
| rdAddr | input | $clog2((2*LMAX+1)*NANT*NANT) | Result memory read address |
| rdData | output | 2*OW | Word at rdAddr: {real, imag}, asynchronous read |
| done | output | 1 | One-cycle pulse when a window's results are stored |

## Verification
With the default parameters, a chip accepted at edge A frees the schedule at edge A+12, so the bench spaces its chips by at least twelve edges. For the last chip of a window, `done` is due at edge A+61. The bench checks that it is low one edge earlier, high at A+61 and low again one edge later, sampling 1 ns after each edge. When the bench inserts stalls, it instead polls for `done` under a bounded count. Memory words are read only after `done`, because the read port is combinational and the memory is fully written by then.

// File: rtl/mcov_pkg.sv
package mcov_pkg;
  localparam int STRW = 16;

  typedef struct packed {
    logic            hold;
    logic            load;
    logic            mulValid;
    logic [STRW-1:0] step;
    logic            shufValid;
    logic [STRW-1:0] shufIdx;
    logic            clear;
  } covStrobe_t;
endpackage

// File: rtl/mcov_ctrl.sv
module mcov_ctrl
  import mcov_pkg::*;
#(
  parameter int NPROD = 48,
  parameter int STEPS = 12,
  parameter int WIN   = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       chipValid,
  input  logic       stall,
  output covStrobe_t str,
  output logic       done
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN, S_SHUF} state_t;

  state_t          state;
  logic [STRW-1:0] step;
  logic [STRW-1:0] chip;
  logic [STRW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      step  <= '0;
      chip  <= '0;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!stall) begin
        case (state)
          S_IDLE: if (chipValid) begin
            state <= S_RUN;
            step  <= '0;
          end
          S_RUN: begin
            if (step == STRW'(STEPS-1)) begin
              step <= '0;
              if (chip == STRW'(WIN-1)) begin
                chip  <= '0;
                state <= S_DRAIN;
              end else begin
                chip  <= chip + 1'b1;
                state <= S_IDLE;
              end
            end else begin
              step <= step + 1'b1;
            end
          end
          S_DRAIN: begin
            state <= S_SHUF;
            idx   <= '0;
          end
          default: begin
            if (idx == STRW'(NPROD-1)) begin
              state <= S_IDLE;
              idx   <= '0;
              done  <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    str.hold      = stall;
    str.load      = (state == S_IDLE) && chipValid && !stall;
    str.mulValid  = (state == S_RUN);
    str.step      = step;
    str.shufValid = (state == S_SHUF);
    str.shufIdx   = idx;
    str.clear     = (state == S_SHUF) && (idx == STRW'(NPROD-1)) && !stall;
  end
endmodule

// File: rtl/mcov_dp.sv
module mcov_dp
  import mcov_pkg::*;
#(
  parameter int NANT  = 4,
  parameter int SW    = 10,
  parameter int LMAX  = 2,
  parameter int NMUL  = 4,
  parameter int WIN   = 10,
  parameter int SHIFT = 4,
  parameter int OW    = 16,
  localparam int NPAIR = NANT * NANT,
  localparam int NLAG  = LMAX + 1,
  localparam int NPROD = NLAG * NPAIR,
  localparam int NWORD = (2 * LMAX + 1) * NPAIR,
  localparam int ADW   = $clog2(NWORD),
  localparam int IW    = $clog2(NPROD),
  localparam int PW    = 2 * SW + 1,
  localparam int AW    = PW + $clog2(WIN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  covStrobe_t        str,
  input  logic [NANT*SW-1:0] chipRe,
  input  logic [NANT*SW-1:0] chipIm,
  input  logic [ADW-1:0]    rdAddr,
  output logic [2*OW-1:0]   rdData
);
  localparam logic signed [AW-1:0] MAXV = AW'((2 ** (OW - 1)) - 1);

  logic signed [SW-1:0] hRe [NLAG][NANT];
  logic signed [SW-1:0] hIm [NLAG][NANT];
  logic signed [PW-1:0] cRe [NMUL];
  logic signed [PW-1:0] cIm [NMUL];
  logic [IW-1:0]        cIdx[NMUL];
  logic                 cOk [NMUL];
  logic signed [PW-1:0] pRe [NMUL];
  logic signed [PW-1:0] pIm [NMUL];
  logic [IW-1:0]        pIdx[NMUL];
  logic                 pOk [NMUL];
  logic                 pVld;
  logic signed [AW-1:0] aRe [NPROD];
  logic signed [AW-1:0] aIm [NPROD];
  logic [2*OW-1:0]      mem [NWORD];

  // sample history: index 0 is the current chip, index k is k chips back
  always_ff @(posedge clk) begin
    if (rst || (!str.hold && str.clear)) begin
      for (int l = 0; l < NLAG; l++)
        for (int a = 0; a < NANT; a++) begin
          hRe[l][a] <= '0;
          hIm[l][a] <= '0;
        end
    end else if (str.load) begin
      for (int a = 0; a < NANT; a++) begin
        hRe[0][a] <= chipRe[a*SW +: SW];
        hIm[0][a] <= chipIm[a*SW +: SW];
      end
      for (int l = 1; l < NLAG; l++)
        for (int a = 0; a < NANT; a++) begin
          hRe[l][a] <= hRe[l-1][a];
          hIm[l][a] <= hIm[l-1][a];
        end
    end
  end

  // shared complex multiplier pool, one product index per unit per step
  for (genvar k = 0; k < NMUL; k++) begin : g_mul
    int p, lg, ia, ib;
    logic ok;
    logic signed [SW-1:0]   aR, aI, bR, bI;
    logic signed [2*SW-1:0] m1, m2, m3, m4;
    always_comb begin
      p  = int'(str.step) * NMUL + k;
      ok = (p < NPROD);
      if (!ok) p = 0;
      lg = p / NPAIR;
      ia = (p % NPAIR) / NANT;
      ib = p % NANT;
      aR = hRe[0][ia];
      aI = hIm[0][ia];
      bR = hRe[lg][ib];
      bI = hIm[lg][ib];
      m1 = aR * bR;
      m2 = aI * bI;
      m3 = aI * bR;
      m4 = aR * bI;
    end
    assign cRe[k]  = PW'(m1) + PW'(m2);
    assign cIm[k]  = PW'(m3) - PW'(m4);
    assign cIdx[k] = IW'(p);
    assign cOk[k]  = ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pVld <= 1'b0;
      for (int k = 0; k < NMUL; k++) begin
        pRe[k] <= '0; pIm[k] <= '0; pIdx[k] <= '0; pOk[k] <= 1'b0;
      end
    end else if (!str.hold) begin
      pVld <= str.mulValid;
      for (int k = 0; k < NMUL; k++) begin
        pRe[k] <= cRe[k]; pIm[k] <= cIm[k]; pIdx[k] <= cIdx[k]; pOk[k] <= cOk[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || (!str.hold && str.clear)) begin
      for (int p = 0; p < NPROD; p++) begin
        aRe[p] <= '0;
        aIm[p] <= '0;
      end
    end else if (!str.hold && pVld) begin
      for (int k = 0; k < NMUL; k++)
        if (pOk[k]) begin
          aRe[pIdx[k]] <= aRe[pIdx[k]] + AW'(pRe[k]);
          aIm[pIdx[k]] <= aIm[pIdx[k]] + AW'(pIm[k]);
        end
    end
  end

  function automatic logic signed [OW-1:0] scaleSat(input logic signed [AW-1:0] v);
    logic signed [AW-1:0] s;
    s = v >>> SHIFT;
    if (s > MAXV) s = MAXV;
    else if (s < -MAXV) s = -MAXV;
    return s[OW-1:0];
  endfunction

  // shuffle: positive-lag word and its conjugate-transposed twin per cycle
  int sIdx, sLag, sI, sJ, addrP, addrN;
  logic signed [OW-1:0] sRe, sIm;
  always_comb begin
    sIdx = int'(str.shufIdx);
    if (sIdx >= NPROD) sIdx = 0;
    sLag  = sIdx / NPAIR;
    sI    = (sIdx % NPAIR) / NANT;
    sJ    = sIdx % NANT;
    sRe   = scaleSat(aRe[sIdx]);
    sIm   = scaleSat(aIm[sIdx]);
    addrP = ((sLag + LMAX) * NANT + sI) * NANT + sJ;
    addrN = ((LMAX - sLag) * NANT + sJ) * NANT + sI;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NWORD; w++) mem[w] <= '0;
    end else if (str.shufValid && !str.hold) begin
      mem[addrP] <= {sRe, sIm};
      if (sLag > 0) mem[addrN] <= {sRe, -sIm};
    end
  end

  assign rdData = (int'(rdAddr) < NWORD) ? mem[rdAddr] : '0;
endmodule

// File: rtl/mcov_top.sv
module mcov_top
  import mcov_pkg::*;
#(
  parameter int NANT  = 4,
  parameter int SW    = 10,
  parameter int LMAX  = 2,
  parameter int NMUL  = 4,
  parameter int WIN   = 10,
  parameter int SHIFT = 4,
  parameter int OW    = 16,
  localparam int NPROD = (LMAX + 1) * NANT * NANT,
  localparam int STEPS = (NPROD + NMUL - 1) / NMUL,
  localparam int ADW   = $clog2((2 * LMAX + 1) * NANT * NANT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               chipValid,
  input  logic               stall,
  input  logic [NANT*SW-1:0] chipRe,
  input  logic [NANT*SW-1:0] chipIm,
  input  logic [ADW-1:0]     rdAddr,
  output logic [2*OW-1:0]    rdData,
  output logic               done
);
  covStrobe_t str;

  mcov_ctrl #(.NPROD(NPROD), .STEPS(STEPS), .WIN(WIN)) u_ctrl (
    .clk(clk), .rst(rst), .chipValid(chipValid), .stall(stall),
    .str(str), .done(done)
  );

  mcov_dp #(
    .NANT(NANT), .SW(SW), .LMAX(LMAX), .NMUL(NMUL),
    .WIN(WIN), .SHIFT(SHIFT), .OW(OW)
  ) u_dp (
    .clk(clk), .rst(rst), .str(str), .chipRe(chipRe), .chipIm(chipIm),
    .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/mcov_chk.sv
module mcov_chk
  import mcov_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       stall,
  input logic       done,
  input covStrobe_t str
);
  // R6: done lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: done only follows a shuffle cycle
  p_done_after_shuf_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(str.shufValid));

  // R7: schedule and shuffle position hold under stall
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(str.step) && $stable(str.shufIdx)));

  // R8: acceptance, multiplying and shuffling never overlap
  p_phases_excl_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({str.load, str.mulValid, str.shufValid}));

  // R8: an accepted chip starts the schedule at step zero
  p_load_starts_r8: assert property (@(posedge clk) disable iff (rst)
    str.load |=> (str.mulValid && str.step == '0));
endmodule

bind mcov_top mcov_chk u_chk (
  .clk(clk), .rst(rst), .stall(stall), .done(done), .str(str)
);

// File: tb/tb_mcov_top.sv
`timescale 1ns/1ps
module tb_mcov_top;
  localparam int NANT = 4, SW = 10, LMAX = 2, NMUL = 4, WIN = 10, SHIFT = 4, OW = 16;
  localparam int NPROD = (LMAX + 1) * NANT * NANT;
  localparam int STEPS = (NPROD + NMUL - 1) / NMUL;
  localparam int NWORD = (2 * LMAX + 1) * NANT * NANT;
  localparam int ADW = $clog2(NWORD);
  localparam int MAXV = (2 ** (OW - 1)) - 1;

  logic clk = 1'b0, rst = 1'b1, chipValid = 1'b0, stall = 1'b0;
  logic [NANT*SW-1:0] chipRe = '0, chipIm = '0;
  logic [ADW-1:0] rdAddr = '0;
  logic [2*OW-1:0] rdData;
  logic done;

  int nChk = 0, nErr = 0;
  int mRe[WIN][NANT];
  int mIm[WIN][NANT];

  mcov_top #(.NANT(NANT), .SW(SW), .LMAX(LMAX), .NMUL(NMUL), .WIN(WIN),
             .SHIFT(SHIFT), .OW(OW)) dut (
    .clk(clk), .rst(rst), .chipValid(chipValid), .stall(stall),
    .chipRe(chipRe), .chipIm(chipIm), .rdAddr(rdAddr), .rdData(rdData), .done(done)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input longint got, input longint exp, input string what);
    nChk++;
    if (got !== exp) begin
      nErr++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic longint satv(input longint v);
    longint s = v >>> SHIFT;
    if (s > MAXV) s = MAXV;
    if (s < -MAXV) s = -MAXV;
    return s;
  endfunction

  // positive-lag entry from the sums in R1, scaled per R3/R4
  task automatic posEntry(input int l, input int i, input int j, output longint er, output longint ei);
    longint sr = 0, si = 0;
    for (int n = l; n < WIN; n++) begin
      sr += longint'(mRe[n][i]) * mRe[n-l][j] + longint'(mIm[n][i]) * mIm[n-l][j];
      si += longint'(mIm[n][i]) * mRe[n-l][j] - longint'(mRe[n][i]) * mIm[n-l][j];
    end
    er = satv(sr);
    ei = satv(si);
  endtask

  task automatic compareMem(input string tag);
    for (int w = 0; w < NWORD; w++) begin
      int lag = w / (NANT * NANT) - LMAX;
      int i = (w / NANT) % NANT;
      int j = w % NANT;
      longint er, ei;
      logic signed [OW-1:0] gr, gi;
      if (lag >= 0) posEntry(lag, i, j, er, ei);
      else begin
        posEntry(-lag, j, i, er, ei);
        ei = -ei;
      end
      rdAddr = ADW'(w);
      #1;
      gr = rdData[2*OW-1:OW];
      gi = rdData[OW-1:0];
      check(lag >= 0 ? {tag, "/R1"} : {tag, "/R2"}, longint'(gr), er, $sformatf("re word %0d", w));
      check(lag >= 0 ? {tag, "/R1"} : {tag, "/R2"}, longint'(gi), ei, $sformatf("im word %0d", w));
    end
  endtask

  task automatic driveChip(input int n);
    for (int a = 0; a < NANT; a++) begin
      chipRe[a*SW +: SW] = SW'(mRe[n][a]);
      chipIm[a*SW +: SW] = SW'(mIm[n][a]);
    end
  endtask

  task automatic sendChip(input int n, input bit last);
    @(negedge clk);
    driveChip(n);
    chipValid = 1'b1;
    @(posedge clk); #1;
    chipValid = 1'b0;
    if (!last) repeat (STEPS) @(posedge clk);
  endtask

  task automatic runTimedWindow(input string tag);
    for (int n = 0; n < WIN - 1; n++) sendChip(n, 1'b0);
    sendChip(WIN - 1, 1'b1);
    repeat (STEPS + NPROD) @(posedge clk); #1;
    check({tag, "/R6"}, done, 0, "done early");
    @(posedge clk); #1;
    check({tag, "/R6"}, done, 1, "done on time");
    @(posedge clk); #1;
    check({tag, "/R6"}, done, 0, "done one cycle");
  endtask

  task automatic waitDone(input string tag);
    int cnt = 0;
    while (!done && cnt < 400) begin
      @(posedge clk); #1;
      cnt++;
    end
    check({tag, "/R7"}, done, 1, "done reached");
  endtask

  task automatic fillRandom(input int span);
    for (int n = 0; n < WIN; n++)
      for (int a = 0; a < NANT; a++) begin
        mRe[n][a] = int'($urandom_range(2 * span)) - span;
        mIm[n][a] = int'($urandom_range(2 * span)) - span;
      end
  endtask

  task automatic t_reset();
    check("R9", done, 0, "done after reset");
    for (int w = 0; w < NWORD; w += 13) begin
      rdAddr = ADW'(w);
      #1;
      check("R9", rdData, 0, $sformatf("word %0d after reset", w));
    end
  endtask

  task automatic t_basic();
    fillRandom(100);
    runTimedWindow("R3");
    compareMem("R3");
  endtask

  task automatic t_second();
    fillRandom(511);
    runTimedWindow("R5");
    compareMem("R5");
  endtask

  task automatic t_sat();
    for (int n = 0; n < WIN; n++)
      for (int a = 0; a < NANT; a++) begin
        mRe[n][a] = (a % 2 == 0) ? 511 : -511;
        mIm[n][a] = (a % 2 == 0) ? 511 : -511;
      end
    runTimedWindow("R4");
    compareMem("R4");
  endtask

  task automatic t_stall();
    fillRandom(300);
    // R7: valid during stall while idle is ignored
    @(negedge clk);
    chipRe = {NANT{10'sd77}};
    chipIm = {NANT{10'sd77}};
    stall = 1'b1; chipValid = 1'b1;
    repeat (3) @(posedge clk); #1;
    stall = 1'b0; chipValid = 1'b0;
    for (int n = 0; n < WIN; n++) begin
      @(negedge clk);
      driveChip(n);
      chipValid = 1'b1;
      @(posedge clk); #1;
      chipValid = 1'b0;
      if (n == 3) begin
        repeat (2) @(posedge clk); #1;
        chipRe = {NANT{-10'sd200}};
        stall = 1'b1; chipValid = 1'b1;
        repeat (6) @(posedge clk); #1;
        stall = 1'b0; chipValid = 1'b0;
        repeat (STEPS + 2) @(posedge clk);
      end else if (n == 5) begin
        // R8: valid while the schedule runs is ignored
        repeat (4) @(posedge clk); #1;
        chipRe = {NANT{10'sd150}};
        chipValid = 1'b1;
        @(posedge clk); #1;
        chipValid = 1'b0;
        repeat (STEPS) @(posedge clk);
      end else if (n < WIN - 1) begin
        repeat (STEPS) @(posedge clk);
      end
    end
    waitDone("R7");
    compareMem("R7/R8");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_basic();
    t_second();
    t_sat();
    t_stall();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nErr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule